// File: doc/BRIEF.md
# Branch and Skip Sequencer

This block resolves the control-flow opcodes of an 8-bit accumulator CPU. It works out the next value of the active program-counter register. The datapath presents an opcode with `valid_i` and supplies the following inputs:

- the PC value after the opcode fetch, which points at the first operand byte;
- up to two operand bytes that have already been fetched;
- the condition sources: the Q output latch, the accumulator, the carry flag, the interrupt-enable flag and four external flag pins.

One clock later the block returns the new PC, a taken flag and the machine-cycle count of the instruction.

Two groups of opcodes are handled:

- **Opcode high nibble 3.** Two-byte short branches replace only the low PC byte, so addressing is page-absolute. A one-byte skip is also in this group.
- **Opcode high nibble C.** Three-byte long branches load all 16 PC bits. Long skips step over two bytes. A no-operation is also in this group.

The long skips encode their condition sense the other way round from the branches: the half with opcode bit 3 clear skips on the negated condition.

The external flag pins are asynchronous and active low. Each pin passes through a two-stage synchronizer before it is tested. Any opcode outside the two groups leaves the PC unchanged.

Top module: `branch_skip_seq`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `taken_o`, `pc_next_o` and `cycles_o` are all zero.
- R2: Each cycle in which `valid_i` is high yields a result, with `valid_o` high, exactly one clock later. When `valid_i` is low, `valid_o` falls and `pc_next_o`, `taken_o` and `cycles_o` hold their values.
- R3: Opcodes 0x30..0x37 are short branches. Their conditions, by low opcode bits 2:0, are:
  - 0: always;
  - 1: Q=1;
  - 2: accumulator equal to 0x00;
  - 3: carry=1;
  - 4..7: external flag 1..4 true.
- R4: Opcodes 0x39..0x3F are short branches on the inverse of the condition with the same low three bits.
- R5: A taken short branch gives `{pc_i[15:8], op_hi_i}`, where `pc_i` is the operand address. A short branch that is not taken gives `pc_i+1`, even when that crosses into the next page.
- R6: Opcode 0x38 always skips one byte: `taken_o`=1 and the result is `pc_i+1`.
- R7: Opcodes 0xC0..0xC3 are long branches on always, Q=1, accumulator zero and carry=1. Opcodes 0xC9..0xCB are long branches on not Q, accumulator non-zero and carry=0. A taken long branch gives `{op_hi_i, op_lo_i}`; one that is not taken gives `pc_i+2`.
- R8: The long skips and their conditions are:
  - 0xC5..0xC7: skip on Q=0, accumulator non-zero, carry=0;
  - 0xCD..0xCF: skip on Q=1, accumulator zero, carry=1;
  - 0xC8: always skips;
  - 0xCC: skips when interrupt-enable=1.

  A skip gives `pc_i+2` and `taken_o`=1. Otherwise the result is `pc_i` and `taken_o`=0. Arithmetic wraps at 16 bits.
- R9: Opcode 0xC4 is a no-operation: the result is `pc_i` and `taken_o`=0.
- R10: `cycles_o` is 3 for every opcode 0xC0..0xCF and 2 for every other opcode. Any opcode outside 0x30..0x3F and 0xC0..0xCF gives `pc_i` with `taken_o`=0.
- R11: An external flag is true when its pin in `ef_ni` is low; bit 0 is flag 1. A test uses the level the pin held two rising edges earlier. After a pin changes, instructions presented at the first and second rising edges see the old level, and from the third edge on they see the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Opcode and operands are presented this cycle |
| opcode_i | input | 8 | Opcode byte |
| op_hi_i | input | 8 | First operand byte (short target, or long target high byte) |
| op_lo_i | input | 8 | Second operand byte (long target low byte) |
| pc_i | input | 16 | PC after the opcode fetch, addressing the first operand |
| q_i | input | 1 | Q output latch state |
| d_i | input | 8 | Accumulator value, tested for zero |
| df_i | input | 1 | Carry flag |
| ie_i | input | 1 | Interrupt-enable flag |
| ef_ni | input | 4 | External flag pins, active low, asynchronous |
| valid_o | output | 1 | Result valid |
| pc_next_o | output | 16 | Next PC value |
| taken_o | output | 1 | Branch or skip taken |
| cycles_o | output | 2 | Machine cycles of the instruction |

## Verification
The bench sweeps all 32 control opcodes and then issues random opcodes with random conditions against a reference model. It places short branches at a page's last byte. A design that took the page from the incremented PC would land in the wrong page on a taken branch; one that dropped the carry on a branch that is not taken would wrap within the page. It also runs long skips at 0xFFFF to expose skip arithmetic that does not wrap. Swapping the skip sense with the branch sense shows up as a mismatch on 0xC5..0xC7 against 0xCD..0xCF. Finally, flag pins toggled next to an issued branch expose a synchronizer with the wrong depth or a flag read without inversion.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [2:0] {
    CK_NONE  = 3'd0,
    CK_SBR   = 3'd1,
    CK_SSKIP = 3'd2,
    CK_LBR   = 3'd3,
    CK_LSKIP = 3'd4,
    CK_NOP   = 3'd5
  } ctl_kind_e;

  localparam logic [3:0] GRP_SHORT = 4'h3;
  localparam logic [3:0] GRP_LONG  = 4'hC;

  // shared selector: always, Q, D==0, DF
  function automatic logic sel_basic(input logic [1:0] idx, input logic q,
                                     input logic dz, input logic df);
    case (idx)
      2'd0:    sel_basic = 1'b1;
      2'd1:    sel_basic = q;
      2'd2:    sel_basic = dz;
      default: sel_basic = df;
    endcase
  endfunction
endpackage

// File: rtl/sbs_flag_sync.sv
module sbs_flag_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sbs_cond_eval.sv
module sbs_cond_eval
  import sbs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_EF = 4
) (
  input  logic [7:0]        opcode_i,
  input  logic              q_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic              df_i,
  input  logic              ie_i,
  input  logic [NUM_EF-1:0] ef_flag_i,
  output ctl_kind_e         kind_o,
  output logic              cond_o
);
  logic [3:0] grp, n;
  logic       dz, base;

  assign grp = opcode_i[7:4];
  assign n   = opcode_i[3:0];
  assign dz  = (d_i == '0);

  always_comb begin
    kind_o = CK_NONE;
    cond_o = 1'b0;
    base   = 1'b0;
    if (grp == GRP_SHORT) begin
      if (n == 4'h8) begin
        kind_o = CK_SSKIP;
        cond_o = 1'b1;
      end else begin
        kind_o = CK_SBR;
        base   = n[2] ? ef_flag_i[n[1:0]] : sel_basic(n[1:0], q_i, dz, df_i);
        cond_o = base ^ n[3];
      end
    end else if (grp == GRP_LONG) begin
      if (n == 4'h8) begin
        kind_o = CK_LSKIP;
        cond_o = 1'b1;
      end else if (!n[2]) begin
        kind_o = CK_LBR;
        base   = sel_basic(n[1:0], q_i, dz, df_i);
        cond_o = base ^ n[3];
      end else if (n == 4'h4) begin
        kind_o = CK_NOP;
      end else begin
        // skip sense: upper half direct, lower half inverted
        kind_o = CK_LSKIP;
        base   = (n[1:0] == 2'd0) ? ie_i : sel_basic(n[1:0], q_i, dz, df_i);
        cond_o = n[3] ? base : ~base;
      end
    end
  end
endmodule

// File: rtl/sbs_target.sv
module sbs_target
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] op_hi_i,
  input  logic [DATA_W-1:0] op_lo_i,
  input  ctl_kind_e         kind_i,
  input  logic              cond_i,
  output logic [ADDR_W-1:0] pc_next_o,
  output logic              taken_o
);
  localparam int PAGE_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] pc_p1, pc_p2, short_tgt, long_tgt;

  assign pc_p1     = pc_i + ADDR_W'(1);
  assign pc_p2     = pc_i + ADDR_W'(2);
  assign short_tgt = {pc_i[ADDR_W-1 -: PAGE_W], op_hi_i};
  assign long_tgt  = ADDR_W'({op_hi_i, op_lo_i});

  always_comb begin
    pc_next_o = pc_i;
    taken_o   = 1'b0;
    unique case (kind_i)
      CK_SBR: begin
        pc_next_o = cond_i ? short_tgt : pc_p1;
        taken_o   = cond_i;
      end
      CK_SSKIP: begin
        pc_next_o = pc_p1;
        taken_o   = 1'b1;
      end
      CK_LBR: begin
        pc_next_o = cond_i ? long_tgt : pc_p2;
        taken_o   = cond_i;
      end
      CK_LSKIP: begin
        pc_next_o = cond_i ? pc_p2 : pc_i;
        taken_o   = cond_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/branch_skip_seq.sv
module branch_skip_seq
  import sbs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int NUM_EF    = 4,
  parameter int SYNC_DEPTH = 2,
  parameter int CYC_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [7:0]        op_hi_i,
  input  logic [7:0]        op_lo_i,
  input  logic [15:0]       pc_i,
  input  logic              q_i,
  input  logic [7:0]        d_i,
  input  logic              df_i,
  input  logic              ie_i,
  input  logic [3:0]        ef_ni,
  output logic              valid_o,
  output logic [15:0]       pc_next_o,
  output logic              taken_o,
  output logic [1:0]        cycles_o
);
  localparam logic [CYC_W-1:0] CYC_SHORT = CYC_W'(2);
  localparam logic [CYC_W-1:0] CYC_LONG  = CYC_W'(3);

  logic [NUM_EF-1:0] ef_sync_n;
  logic [NUM_EF-1:0] ef_flag;
  ctl_kind_e         kind;
  logic              cond;
  logic [ADDR_W-1:0] pc_nx;
  logic              tk;
  logic [CYC_W-1:0]  cyc;

  sbs_flag_sync #(
    .WIDTH  (NUM_EF),
    .STAGES (SYNC_DEPTH),
    .RST_VAL({NUM_EF{1'b1}})
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ef_ni),
    .sync_o (ef_sync_n)
  );

  assign ef_flag = ~ef_sync_n;

  sbs_cond_eval #(.DATA_W(DATA_W), .NUM_EF(NUM_EF)) u_cond (
    .opcode_i (opcode_i),
    .q_i      (q_i),
    .d_i      (d_i),
    .df_i     (df_i),
    .ie_i     (ie_i),
    .ef_flag_i(ef_flag),
    .kind_o   (kind),
    .cond_o   (cond)
  );

  sbs_target #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tgt (
    .pc_i     (pc_i),
    .op_hi_i  (op_hi_i),
    .op_lo_i  (op_lo_i),
    .kind_i   (kind),
    .cond_i   (cond),
    .pc_next_o(pc_nx),
    .taken_o  (tk)
  );

  assign cyc = (opcode_i[7:4] == GRP_LONG) ? CYC_LONG : CYC_SHORT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      pc_next_o <= '0;
      taken_o   <= 1'b0;
      cycles_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        pc_next_o <= pc_nx;
        taken_o   <= tk;
        cycles_o  <= cyc;
      end
    end
  end
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [7:0]  opcode_i,
  input logic [7:0]  op_hi_i,
  input logic [7:0]  op_lo_i,
  input logic [15:0] pc_i,
  input logic        valid_o,
  input logic [15:0] pc_next_o,
  input logic        taken_o,
  input logic [1:0]  cycles_o
);
  p_valid_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));

  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> ($stable(pc_next_o) && $stable(taken_o) && $stable(cycles_o)));

  p_short_page_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o && $past(opcode_i[7:4]) == 4'h3 && $past(opcode_i) != 8'h38)
      |-> (pc_next_o == {$past(pc_i[15:8]), $past(op_hi_i)}));

  p_skip_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(opcode_i) == 8'h38)
      |-> (taken_o && pc_next_o == $past(pc_i) + 16'd1));

  p_long_tgt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o && $past(opcode_i[7:4]) == 4'hC && !$past(opcode_i[2])
       && $past(opcode_i) != 8'hC8)
      |-> (pc_next_o == {$past(op_hi_i), $past(op_lo_i)}));

  p_nop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(opcode_i) == 8'hC4) |-> (!taken_o && pc_next_o == $past(pc_i)));

  p_cycles_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cycles_o == (($past(opcode_i[7:4]) == 4'hC) ? 2'd3 : 2'd2)));
endmodule

bind branch_skip_seq sbs_checker u_sbs_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .opcode_i (opcode_i),
  .op_hi_i  (op_hi_i),
  .op_lo_i  (op_lo_i),
  .pc_i     (pc_i),
  .valid_o  (valid_o),
  .pc_next_o(pc_next_o),
  .taken_o  (taken_o),
  .cycles_o (cycles_o)
);

// File: tb/branch_skip_seq_bench.sv
module branch_skip_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  opcode_i = '0, op_hi_i = '0, op_lo_i = '0, d_i = '0;
  logic [15:0] pc_i = '0;
  logic        q_i = 1'b0, df_i = 1'b0, ie_i = 1'b0;
  logic [3:0]  ef_ni = 4'hF;
  logic        valid_o, taken_o;
  logic [15:0] pc_next_o;
  logic [1:0]  cycles_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_skip_seq u_branch_skip_seq (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
    .op_hi_i(op_hi_i), .op_lo_i(op_lo_i), .pc_i(pc_i), .q_i(q_i), .d_i(d_i),
    .df_i(df_i), .ie_i(ie_i), .ef_ni(ef_ni), .valid_o(valid_o),
    .pc_next_o(pc_next_o), .taken_o(taken_o), .cycles_o(cycles_o)
  );

  // reference: {cycles, taken, pc}
  function automatic logic [18:0] model(input logic [7:0] op, input logic [15:0] pc,
      input logic [7:0] hi, input logic [7:0] lo, input logic q, input logic [7:0] d,
      input logic df, input logic ie, input logic [3:0] efn);
    logic dz, c, tk;
    logic [15:0] nx;
    logic [1:0] cy;
    logic [7:0] sc;
    logic [3:0] lc;
    dz = (d == 8'h00);
    sc = {~efn[3], ~efn[2], ~efn[1], ~efn[0], df, dz, q, 1'b1};
    lc = {df, dz, q, 1'b1};
    nx = pc; tk = 1'b0;
    cy = (op[7:4] == 4'hC) ? 2'd3 : 2'd2;
    if (op == 8'h38) begin
      tk = 1'b1; nx = pc + 16'd1;
    end else if (op >= 8'h30 && op <= 8'h3F) begin
      c = (op <= 8'h37) ? sc[op - 8'h30] : !sc[op - 8'h38];
      tk = c; nx = c ? {pc[15:8], hi} : pc + 16'd1;
    end else if (op == 8'hC4) begin
      tk = 1'b0;
    end else if ((op >= 8'hC0 && op <= 8'hC3) || (op >= 8'hC9 && op <= 8'hCB)) begin
      c = (op <= 8'hC3) ? lc[op - 8'hC0] : !lc[op - 8'hC8];
      tk = c; nx = c ? {hi, lo} : pc + 16'd2;
    end else if (op[7:4] == 4'hC) begin
      if (op == 8'hC8) c = 1'b1;
      else if (op == 8'hCC) c = ie;
      else if (op <= 8'hC7) c = !lc[op - 8'hC4];
      else c = lc[op - 8'hCC];
      tk = c; nx = c ? pc + 16'd2 : pc;
    end
    return {cy, tk, nx};
  endfunction

  function automatic string req_of(input logic [7:0] op);
    if (op == 8'h38) return "R6";
    if (op >= 8'h30 && op <= 8'h37) return "R3";
    if (op >= 8'h39 && op <= 8'h3F) return "R4";
    if (op == 8'hC4) return "R9";
    if ((op >= 8'hC0 && op <= 8'hC3) || (op >= 8'hC9 && op <= 8'hCB)) return "R7";
    if (op[7:4] == 4'hC) return "R8";
    return "R10";
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_env(input logic q, input logic [7:0] d, input logic df,
                         input logic ie, input logic [3:0] efn);
    @(negedge clk);
    q_i = q; d_i = d; df_i = df; ie_i = ie; ef_ni = efn; valid_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(input string req, input logic [7:0] op, input logic [15:0] pc,
                       input logic [7:0] hi, input logic [7:0] lo);
    logic [18:0] e;
    e = model(op, pc, hi, lo, q_i, d_i, df_i, ie_i, ef_ni);
    opcode_i = op; pc_i = pc; op_hi_i = hi; op_lo_i = lo; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R2", "valid", 32'(valid_o), 32'd1);
    chk(req, "pc", 32'(pc_next_o), 32'(e[15:0]));
    chk(req, "taken", 32'(taken_o), 32'(e[16]));
    chk("R10", "cycles", 32'(cycles_o), 32'(e[18:17]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] hold_pc;
    void'($urandom(32'd1802));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "valid", 32'(valid_o), 32'd0);
    chk("R1", "pc", 32'(pc_next_o), 32'd0);
    chk("R1", "taken", 32'(taken_o), 32'd0);
    chk("R1", "cycles", 32'(cycles_o), 32'd0);
    rst_n = 1'b1;

    // sweep of all control opcodes under two condition sets
    set_env(1'b1, 8'h00, 1'b1, 1'b1, 4'b1010);
    for (int i = 0; i < 16; i++) issue(req_of(8'h30 + 8'(i)), 8'h30 + 8'(i), 16'h4421, 8'h9C, 8'h55);
    for (int i = 0; i < 16; i++) issue(req_of(8'hC0 + 8'(i)), 8'hC0 + 8'(i), 16'h4421, 8'h9C, 8'h55);
    set_env(1'b0, 8'h17, 1'b0, 1'b0, 4'b0101);
    for (int i = 0; i < 16; i++) issue(req_of(8'h30 + 8'(i)), 8'h30 + 8'(i), 16'h0803, 8'h11, 8'hEE);
    for (int i = 0; i < 16; i++) issue(req_of(8'hC0 + 8'(i)), 8'hC0 + 8'(i), 16'h0803, 8'h11, 8'hEE);

    // R5 page corners: operand at last byte of page
    set_env(1'b0, 8'h00, 1'b0, 1'b0, 4'hF);
    issue("R5", 8'h30, 16'h12FF, 8'h40, 8'h00);
    chk("R5", "taken page", 32'(pc_next_o), 32'h1240);
    issue("R5", 8'h3A, 16'h12FF, 8'h40, 8'h00);
    chk("R5", "not-taken cross", 32'(pc_next_o), 32'h1300);
    // R8 wrap at top of memory
    issue("R8", 8'hC8, 16'hFFFF, 8'h00, 8'h00);
    chk("R8", "skip wrap", 32'(pc_next_o), 32'h0001);
    issue("R7", 8'hC2, 16'hFFFF, 8'hAB, 8'hCD);
    chk("R7", "long target", 32'(pc_next_o), 32'hABCD);

    // R2 idle: valid falls, outputs hold
    hold_pc = pc_next_o;
    opcode_i = 8'h30; pc_i = 16'h0000; op_hi_i = 8'h00;
    @(negedge clk);
    chk("R2", "idle valid", 32'(valid_o), 32'd0);
    chk("R2", "idle hold", 32'(pc_next_o), 32'(hold_pc));

    // R11 synchronizer timing: EF1 goes low with back-to-back B1 issues
    set_env(1'b0, 8'h01, 1'b0, 1'b0, 4'hF);
    ef_ni = 4'hE; opcode_i = 8'h34; pc_i = 16'h2000; op_hi_i = 8'h80; valid_i = 1'b1;
    @(negedge clk);
    chk("R11", "edge1 old level", 32'(taken_o), 32'd0);
    @(negedge clk);
    chk("R11", "edge2 old level", 32'(taken_o), 32'd0);
    @(negedge clk);
    chk("R11", "edge3 new level", 32'(taken_o), 32'd1);
    chk("R11", "edge3 target", 32'(pc_next_o), 32'h2080);
    valid_i = 1'b0;

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [7:0] op;
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 4) op = 8'h30 | 8'($urandom_range(0, 15));
      else if (sel < 8) op = 8'hC0 | 8'($urandom_range(0, 15));
      else op = 8'($urandom_range(0, 255));
      set_env(1'($urandom), ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom),
              1'($urandom), 1'($urandom), 4'($urandom));
      issue(req_of(op), op, 16'($urandom), 8'($urandom), 8'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule